// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Register

This block carries a single message word from a writer clocked by one clock to a reader clocked by an unrelated clock. The message goes around the bulk FIFO instead of through it. A writer stores a word by asserting its enable together with its mailbox select. From then on an active-low "mail full" flag shows that a message is waiting. While that flag is low, every further write attempt is dropped, so the stored word cannot be overwritten before it has been consumed.

On the reader side, a select input steers the read-data mux. When the select is high the mux shows the mailbox word; when it is low it shows the FIFO output register, which enters from outside. The message is consumed by a read with the mailbox select high. That read raises the flag again. The write and the read each flip a toggle bit, and each toggle crosses to the opposite clock through a two-flop synchronizer. As a result each side has its own view of the flag: `wrFlagN` in the writer domain and `rdFlagN` in the reader domain.

The register is only as wide as the narrow port's current bus width. A write keeps just the low bits for that width and stores zero in the rest. One asynchronous clear stands for a master or partial reset of the associated FIFO. It empties the mailbox and raises both flags.

Top module: `mbx_bypass`

## Requirements
- R1: While `clearN` is low, and after it is released, `wrFlagN` and `rdFlagN` are both high and the mailbox word reads as zero.
- R2: A rising `clkWr` edge with `wrEn`, `wrMbSel` and `wrFlagN` all high stores the word, and `wrFlagN` is low after that edge.
- R3: A write attempt made while `wrFlagN` is low is ignored, and the stored word remains the first one written.
- R4: A write with `wrMbSel` low leaves the mailbox untouched, and both flags stay high.
- R5: After a stored write, `rdFlagN` goes low within three `clkRd` edges. It then stays low until a mailbox read.
- R6: `rdData` shows the mailbox word while `rdMbSel` is high and `fifoData` while `rdMbSel` is low.
- R7: A rising `clkRd` edge with `rdEn` and `rdMbSel` high while `rdFlagN` is low consumes the message, and `rdFlagN` is high after that edge.
- R8: After the consuming read, `wrFlagN` returns high within four `clkWr` edges, and a new write is then accepted.
- R9: A mailbox read made while `rdFlagN` is high has no effect: both flags stay high.
- R10: `busSize` selects the stored width. 2'b00 and 2'b11 keep all `WIDE_W` bits, 2'b01 keeps the low `WIDE_W/2` bits, and 2'b10 keeps the low `WIDE_W/4` bits. Bits above the kept width are stored as zero.
- R11: Pulling `clearN` low while a message is pending raises both flags at once and clears the mailbox word to zero.
- R12: A write attempted on the `clkWr` edge at which the returning acknowledge has not yet raised `wrFlagN` is ignored. The write on the first edge after `wrFlagN` is seen high is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkWr | input | 1 | Writer-side clock |
| clkRd | input | 1 | Reader-side clock |
| clearN | input | 1 | Asynchronous active-low FIFO reset (master or partial) |
| busSize | input | 2 | Narrow-port bus width code |
| wrEn | input | 1 | Writer transfer enable |
| wrMbSel | input | 1 | Writer selects mailbox |
| wrData | input | WIDE_W | Writer data |
| wrFlagN | output | 1 | Mail-full flag, writer view, active low |
| rdEn | input | 1 | Reader transfer enable |
| rdMbSel | input | 1 | Reader selects mailbox (mux steer and consume) |
| fifoData | input | WIDE_W | FIFO output register contents |
| rdData | output | WIDE_W | Reader-port data |
| rdFlagN | output | 1 | Mail-full flag, reader view, active low |

## Verification
Two things can land on the same writer edge: a fresh write attempt, and the synchronized read acknowledge that is about to free the mailbox. To provoke this, the bench runs the consuming read in parallel with a stream of writes, each carrying a distinct word, on every writer cycle. The case is judged by reading back the mailbox. The stored word must be the one presented on the first edge after `wrFlagN` was observed high, and no earlier word may appear. A second collision, a clear arriving while mail is pending, is checked by observing that both flags rise and the data reads zero while `clearN` is still low.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    SZ_FULL     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_QUARTER  = 2'b10,
    SZ_FULL_ALT = 2'b11
  } busSize_e;

  // strobes from control to datapath, writer clock domain
  typedef struct packed {
    logic load;   // capture wrData into the mailbox
    logic held;   // a message is outstanding (writer view)
  } mbxStrobe_t;

endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clkWr,
  input  logic       wrRstN,
  input  logic       clkRd,
  input  logic       rdRstN,
  input  logic       wrEn,
  input  logic       wrMbSel,
  input  logic       rdEn,
  input  logic       rdMbSel,
  output logic       wrFlagN,
  output logic       rdFlagN,
  output mbxStrobe_t strobe
);
  logic wrTgl;     // flips on each stored write (writer domain)
  logic ackTgl;    // flips on each consuming read (reader domain)
  logic ackSeen;   // ackTgl seen in writer domain
  logic wrSeen;    // wrTgl seen in reader domain
  logic writeGo;
  logic readGo;

  mbx_sync2 #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(clkWr), .rstN(wrRstN), .d(ackTgl), .q(ackSeen)
  );

  mbx_sync2 #(.STAGES(SYNC_STAGES)) u_wrSync (
    .clk(clkRd), .rstN(rdRstN), .d(wrTgl), .q(wrSeen)
  );

  // writer side
  assign wrFlagN = (wrTgl == ackSeen);
  assign writeGo = wrEn & wrMbSel & wrFlagN;

  always_ff @(posedge clkWr or negedge wrRstN) begin
    if (!wrRstN)      wrTgl <= 1'b0;
    else if (writeGo) wrTgl <= ~wrTgl;
  end

  // reader side
  assign rdFlagN = (wrSeen == ackTgl);
  assign readGo  = rdEn & rdMbSel & ~rdFlagN;

  always_ff @(posedge clkRd or negedge rdRstN) begin
    if (!rdRstN)     ackTgl <= 1'b0;
    else if (readGo) ackTgl <= ~ackTgl;
  end

  always_comb begin
    strobe.load = writeGo;
    strobe.held = ~wrFlagN;
  end

  // R2: an accepted write drops the writer flag
  p_flag_drop_r2: assert property (@(posedge clkWr) disable iff (!wrRstN)
    (wrEn && wrMbSel && wrFlagN) |=> !wrFlagN);

  // R9: with no write attempt, a high writer flag stays high
  p_idle_high_r9: assert property (@(posedge clkWr) disable iff (!wrRstN)
    (wrFlagN && !(wrEn && wrMbSel)) |=> wrFlagN);

  // R5: pending mail stays visible to the reader until consumed
  p_pend_hold_r5: assert property (@(posedge clkRd) disable iff (!rdRstN)
    (!rdFlagN && !(rdEn && rdMbSel)) |=> !rdFlagN);

  // R7: a consuming read raises the reader flag
  p_ack_r7: assert property (@(posedge clkRd) disable iff (!rdRstN)
    (rdEn && rdMbSel && !rdFlagN) |=> rdFlagN);

endmodule

// File: rtl/mbx_dpath.sv
module mbx_dpath
  import mbx_pkg::*;
#(
  parameter int WIDE_W = 36
) (
  input  logic              clkWr,
  input  logic              wrRstN,
  input  mbxStrobe_t        strobe,
  input  logic [1:0]        busSize,
  input  logic [WIDE_W-1:0] wrData,
  input  logic              rdMbSel,
  input  logic [WIDE_W-1:0] fifoData,
  output logic [WIDE_W-1:0] rdData
);
  localparam int HALF_W  = WIDE_W / 2;
  localparam int QUART_W = WIDE_W / 4;

  logic [WIDE_W-1:0] mailReg;
  logic [WIDE_W-1:0] keepMask;
  int                laneW;

  always_comb begin
    unique case (busSize_e'(busSize))
      SZ_HALF:    laneW = HALF_W;
      SZ_QUARTER: laneW = QUART_W;
      default:    laneW = WIDE_W;
    endcase
    for (int i = 0; i < WIDE_W; i++) keepMask[i] = (i < laneW);
  end

  always_ff @(posedge clkWr or negedge wrRstN) begin
    if (!wrRstN)          mailReg <= '0;
    else if (strobe.load) mailReg <= wrData & keepMask;
  end

  assign rdData = rdMbSel ? mailReg : fifoData;

  // R3: the stored word cannot change while a message is outstanding
  p_hold_r3: assert property (@(posedge clkWr) disable iff (!wrRstN)
    strobe.held |=> $stable(mailReg));

endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
  import mbx_pkg::*;
#(
  parameter int WIDE_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkWr,
  input  logic              clkRd,
  input  logic              clearN,
  input  logic [1:0]        busSize,
  input  logic              wrEn,
  input  logic              wrMbSel,
  input  logic [WIDE_W-1:0] wrData,
  output logic              wrFlagN,
  input  logic              rdEn,
  input  logic              rdMbSel,
  input  logic [WIDE_W-1:0] fifoData,
  output logic [WIDE_W-1:0] rdData,
  output logic              rdFlagN
);
  logic       wrRstN;
  logic       rdRstN;
  mbxStrobe_t strobe;

  // asynchronous assert, synchronous release in each domain
  mbx_sync2 #(.STAGES(2)) u_wrRst (
    .clk(clkWr), .rstN(clearN), .d(1'b1), .q(wrRstN)
  );

  mbx_sync2 #(.STAGES(2)) u_rdRst (
    .clk(clkRd), .rstN(clearN), .d(1'b1), .q(rdRstN)
  );

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkWr   (clkWr),
    .wrRstN  (wrRstN),
    .clkRd   (clkRd),
    .rdRstN  (rdRstN),
    .wrEn    (wrEn),
    .wrMbSel (wrMbSel),
    .rdEn    (rdEn),
    .rdMbSel (rdMbSel),
    .wrFlagN (wrFlagN),
    .rdFlagN (rdFlagN),
    .strobe  (strobe)
  );

  mbx_dpath #(.WIDE_W(WIDE_W)) u_dpath (
    .clkWr    (clkWr),
    .wrRstN   (wrRstN),
    .strobe   (strobe),
    .busSize  (busSize),
    .wrData   (wrData),
    .rdMbSel  (rdMbSel),
    .fifoData (fifoData),
    .rdData   (rdData)
  );

endmodule

// File: tb/mbx_bypass_bench.sv
module mbx_bypass_bench;
  localparam int WIDE_W = 36;
  typedef logic [WIDE_W-1:0] word_t;

  logic  clkWr = 0, clkRd = 0;
  logic  clearN = 0;
  logic  [1:0] busSize = 2'b00;
  logic  wrEn = 0, wrMbSel = 0, rdEn = 0, rdMbSel = 0;
  word_t wrData = '0, fifoData = '0;
  logic  wrFlagN, rdFlagN;
  word_t rdData;

  int checks = 0;
  int fails  = 0;

  always #10 clkWr = ~clkWr;   // 50 MHz
  always #13 clkRd = ~clkRd;

  mbx_bypass #(.WIDE_W(WIDE_W)) u_mbx_bypass (
    .clkWr(clkWr), .clkRd(clkRd), .clearN(clearN), .busSize(busSize),
    .wrEn(wrEn), .wrMbSel(wrMbSel), .wrData(wrData), .wrFlagN(wrFlagN),
    .rdEn(rdEn), .rdMbSel(rdMbSel), .fifoData(fifoData),
    .rdData(rdData), .rdFlagN(rdFlagN)
  );

  task automatic check(input bit ok, input string req, input word_t act, input word_t exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic writeMail(input word_t d);
    @(negedge clkWr);
    wrData = d; wrEn = 1; wrMbSel = 1;
    @(negedge clkWr);
    wrEn = 0; wrMbSel = 0;
  endtask

  task automatic waitRdPending(input string req);
    int n = 0;
    while (rdFlagN && n < 4) begin @(negedge clkRd); n++; end
    check(!rdFlagN && n <= 3, req, word_t'(n), word_t'(3));
  endtask

  task automatic peekMail(input word_t exp, input string req);
    @(negedge clkRd);
    rdMbSel = 1;
    #1;
    check(rdData === exp, req, rdData, exp);
    rdMbSel = 0;
  endtask

  task automatic readEdge();
    @(negedge clkRd);
    rdEn = 1; rdMbSel = 1;
    @(negedge clkRd);
    rdEn = 0; rdMbSel = 0;
  endtask

  task automatic waitWrFree(input string req);
    int n = 0;
    while (!wrFlagN && n < 6) begin @(negedge clkWr); n++; end
    check(wrFlagN && n <= 4, req, word_t'(n), word_t'(4));
  endtask

  task automatic consume();
    readEdge();
    waitWrFree("R8");
  endtask

  task automatic t_reset();
    clearN = 0;
    repeat (3) @(negedge clkWr);
    check(wrFlagN === 1'b1 && rdFlagN === 1'b1, "R1", word_t'({wrFlagN, rdFlagN}), word_t'(2'b11));
    clearN = 1;
    repeat (4) @(negedge clkRd);
    check(wrFlagN === 1'b1 && rdFlagN === 1'b1, "R1", word_t'({wrFlagN, rdFlagN}), word_t'(2'b11));
    peekMail('0, "R1");
  endtask

  task automatic t_basic();
    word_t d = 36'h9_A5C3_1E77;
    writeMail(d);
    check(wrFlagN === 1'b0, "R2", word_t'(wrFlagN), '0);
    waitRdPending("R5");
    peekMail(d, "R6");
    @(negedge clkRd);
    fifoData = 36'h1_2345_6789; rdMbSel = 0;
    #1;
    check(rdData === 36'h1_2345_6789, "R6", rdData, 36'h1_2345_6789);
    readEdge();
    check(rdFlagN === 1'b1, "R7", word_t'(rdFlagN), word_t'(1));
    waitWrFree("R8");
    writeMail(36'h0_0000_00FF);
    check(wrFlagN === 1'b0, "R8", word_t'(wrFlagN), '0);
    waitRdPending("R5");
    consume();
  endtask

  task automatic t_blocked();
    writeMail(36'h3_1111_0001);
    writeMail(36'h4_2222_0002);
    check(wrFlagN === 1'b0, "R3", word_t'(wrFlagN), '0);
    waitRdPending("R5");
    peekMail(36'h3_1111_0001, "R3");
    consume();
  endtask

  task automatic t_unselected();
    @(negedge clkWr);
    wrData = 36'h7_7777_7777; wrEn = 1; wrMbSel = 0;
    repeat (3) @(negedge clkWr);
    wrEn = 0;
    check(wrFlagN === 1'b1, "R4", word_t'(wrFlagN), word_t'(1));
    repeat (4) @(negedge clkRd);
    check(rdFlagN === 1'b1, "R4", word_t'(rdFlagN), word_t'(1));
    peekMail(36'h3_1111_0001, "R4");
  endtask

  task automatic t_emptyRead();
    @(negedge clkRd);
    rdEn = 1; rdMbSel = 1;
    repeat (3) @(negedge clkRd);
    rdEn = 0; rdMbSel = 0;
    repeat (5) @(negedge clkWr);
    check(wrFlagN === 1'b1, "R9", word_t'(wrFlagN), word_t'(1));
    check(rdFlagN === 1'b1, "R9", word_t'(rdFlagN), word_t'(1));
  endtask

  task automatic t_width();
    busSize = 2'b01;
    writeMail('1);
    waitRdPending("R5");
    peekMail(36'h0_0003_FFFF, "R10");
    consume();
    busSize = 2'b10;
    writeMail('1);
    waitRdPending("R5");
    peekMail(36'h0_0000_01FF, "R10");
    consume();
    busSize = 2'b11;
    writeMail('1);
    waitRdPending("R5");
    peekMail('1, "R10");
    consume();
    busSize = 2'b00;
  endtask

  task automatic t_clearPending();
    writeMail(36'h5_DEAD_BEEF);
    waitRdPending("R5");
    #3 clearN = 0;
    #2;
    rdMbSel = 1;
    #1;
    check(wrFlagN === 1'b1 && rdFlagN === 1'b1, "R11", word_t'({wrFlagN, rdFlagN}), word_t'(2'b11));
    check(rdData === '0, "R11", rdData, '0);
    rdMbSel = 0;
    repeat (2) @(negedge clkWr);
    clearN = 1;
    repeat (4) @(negedge clkRd);
  endtask

  task automatic t_race();
    word_t expWord = '0;
    bit    taken = 0;
    writeMail(36'h2_0000_00AA);
    waitRdPending("R5");
    fork
      readEdge();
      begin
        for (int k = 0; k < 12; k++) begin
          @(negedge clkWr);
          wrData = word_t'(36'h100 + k); wrEn = 1; wrMbSel = 1;
          if (wrFlagN) begin
            expWord = wrData; taken = 1;
            @(negedge clkWr);
            wrEn = 0; wrMbSel = 0;
            break;
          end
        end
        wrEn = 0; wrMbSel = 0;
      end
    join
    check(taken && wrFlagN === 1'b0, "R12", word_t'({taken, wrFlagN}), word_t'(2'b10));
    waitRdPending("R5");
    peekMail(expWord, "R12");
    consume();
  endtask

  initial begin
    repeat (150000) @(posedge clkWr);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_basic();
    t_blocked();
    t_unselected();
    t_emptyRead();
    t_width();
    t_clearPending();
    t_race();
    summary();
  end

endmodule